// File: doc/BRIEF.md
# Byte-Granular Write Coalescing Buffer

This block sits between a core's store path and a system bus and merges small stores into whole cache lines before they reach the bus. It holds two line buffers of 128 bytes each. Every store names a line, an 8-byte word inside that line, the data, and one enable bit per byte. A store whose line is already held in a buffer is merged into that buffer byte by byte. A store to a new line takes a free buffer. When neither buffer is free, the older one is flushed first and the store waits.

When a buffer is flushed, it leaves as one whole-line write if every byte is valid. Otherwise it leaves as a series of aligned writes that cover only the valid bytes. The walk runs from low to high addresses and uses 32-byte and 16-byte writes wherever an aligned, fully valid span exists. Any other data goes out as 8-byte-word writes with byte enables. A drain input flushes everything, oldest buffer first, and the block reports when both buffers are empty.

Top module: `wcb_coalesce`

## Requirements
- R1: After reset, `st_ready` is 1 (with `drain_req` low), `bw_valid` is 0 and `drain_done` is 1. `drain_done` is 1 exactly when no buffer holds a line.
- R2: Stores to a line already held merge byte by byte. A byte whose `st_be` bit is set takes the new value and becomes valid. A byte whose bit is clear keeps its earlier value and validity. Bit k of `st_be` selects byte k of the word given by `st_word` (0..15), which is line byte `st_word*8+k`.
- R3: A store to a line not held takes a free buffer. If both buffers are occupied, `st_ready` stays 0, the older buffer is flushed, and the store is accepted only after that buffer is released.
- R4: A buffer whose 128 bytes are all valid is flushed as exactly one write with `bw_size`=3 (whole line) and `bw_off`=0.
- R5: A buffer with holes is flushed from low to high byte offsets. At each 8-byte step the block issues, in order of preference, a 32-byte write (`bw_size`=2) if the offset is 32-aligned and all 32 bytes are valid, or a 16-byte write (`bw_size`=1) if the offset is 16-aligned and all 16 bytes are valid. Otherwise it issues one 8-byte-word write (`bw_size`=0) with `bw_be` equal to that word's valid mask. A word with no valid byte produces no write. For sizes 1 to 3, `bw_be` is all ones.
- R6: While `drain_req` is 1, `st_ready` is 0 and the occupied buffers are flushed in the order they were allocated, oldest first.
- R7: A write held with `bw_ready` low keeps `bw_valid` and its line, offset and size unchanged. A buffer is released only when its last write is accepted. Its valid mask is then cleared, so a later line placed in it flushes only its own bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store request present |
| st_ready | output | 1 | Store accepted at this edge when valid |
| st_line | input | TAG_W | Line address tag of the store |
| st_word | input | 4 | 8-byte word index within the line |
| st_data | input | 64 | Store data, byte k in bits 8k+7:8k |
| st_be | input | 8 | Byte enables of the store |
| drain_req | input | 1 | Flush all buffers, hold off stores |
| drain_done | output | 1 | No buffer holds a line |
| bw_valid | output | 1 | Bus write request present |
| bw_ready | input | 1 | Bus accepts the write at this edge |
| bw_line | output | TAG_W | Line tag of the write |
| bw_off | output | 7 | Byte offset of the write in the line |
| bw_size | output | 2 | 0: word with enables, 1: 16 B, 2: 32 B, 3: whole line |
| bw_be | output | 8 | Byte enables for size 0, all ones otherwise |
| bw_data | output | 1024 | Line contents, byte n in bits 8n+7:8n |

## Verification
A line filled with every byte valid shows that the whole-line write replaces the piecewise walk. A sparse line with 32-byte, 16-byte, full-word, part-word and empty stretches, placed at chosen alignments, shows that each size is picked only where it is both aligned and fully valid. Two overlapping stores to one word check that enabled bytes are overwritten and disabled bytes are kept. Three distinct lines with the bus stalled check the stall, the age order and the held request. A last store into a reused buffer shows that its old mask is gone.

// File: rtl/wcb_pkg.sv
package wcb_pkg;
  localparam int unsigned LINE_BYTES = 128;
  localparam int unsigned WORD_BYTES = 8;
  localparam int unsigned NBUF       = 2;
  localparam int unsigned CHUNKS     = LINE_BYTES / WORD_BYTES;
  localparam int unsigned CIDX_W     = $clog2(CHUNKS);
  localparam int unsigned OFF_W      = $clog2(LINE_BYTES);
  localparam int unsigned BIDX_W     = $clog2(NBUF);

  typedef enum logic [1:0] {
    SZ_DW   = 2'd0,
    SZ_16   = 2'd1,
    SZ_32   = 2'd2,
    SZ_LINE = 2'd3
  } wsize_e;

  typedef struct packed {
    logic   vld;
    wsize_e sz;
  } pick_t;

  // Choose the write issued at chunk c of a line with byte-valid mask m.
  function automatic pick_t pick_write(input logic [LINE_BYTES-1:0] m,
                                       input logic [CIDX_W-1:0] c);
    pick_t p;
    logic [LINE_BYTES-1:0] sh;
    sh    = m >> (int'(c) * WORD_BYTES);
    p.vld = 1'b1;
    if (c == '0 && &m)                   p.sz = SZ_LINE;
    else if (c[1:0] == 2'b00 && &sh[31:0]) p.sz = SZ_32;
    else if (c[0] == 1'b0 && &sh[15:0])    p.sz = SZ_16;
    else begin
      p.sz  = SZ_DW;
      p.vld = |sh[WORD_BYTES-1:0];
    end
    return p;
  endfunction

  // Number of chunks a write of the given size covers.
  function automatic logic [CIDX_W:0] span_chunks(input wsize_e sz);
    case (sz)
      SZ_LINE: return (CIDX_W+1)'(CHUNKS);
      SZ_32:   return (CIDX_W+1)'(32 / WORD_BYTES);
      SZ_16:   return (CIDX_W+1)'(16 / WORD_BYTES);
      default: return (CIDX_W+1)'(1);
    endcase
  endfunction
endpackage

// File: rtl/wcb_line.sv
module wcb_line
  import wcb_pkg::*;
#(
  parameter int unsigned TAG_W = 26
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      alloc,
  input  logic [TAG_W-1:0]          tag_in,
  input  logic                      wr_en,
  input  logic [CIDX_W-1:0]         wr_word,
  input  logic [WORD_BYTES*8-1:0]   wr_data,
  input  logic [WORD_BYTES-1:0]     wr_be,
  input  logic                      clr,
  output logic [TAG_W-1:0]          tag_o,
  output logic [LINE_BYTES*8-1:0]   data_o,
  output logic [LINE_BYTES-1:0]     mask_o
);
  localparam int unsigned WB_W = $clog2(WORD_BYTES);

  logic [TAG_W-1:0]        tag_q;
  logic [LINE_BYTES*8-1:0] data_q;
  logic [LINE_BYTES-1:0]   mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tag_q  <= '0;
      data_q <= '0;
      mask_q <= '0;
    end else begin
      if (alloc) tag_q <= tag_in;
      if (clr) begin
        mask_q <= '0;
      end else if (wr_en) begin
        for (int k = 0; k < int'(WORD_BYTES); k++) begin
          if (wr_be[k]) begin
            mask_q[{wr_word, WB_W'(k)}]          <= 1'b1;
            data_q[8*{wr_word, WB_W'(k)} +: 8] <= wr_data[8*k +: 8];
          end
        end
      end
    end
  end

  assign tag_o  = tag_q;
  assign data_o = data_q;
  assign mask_o = mask_q;

  // R7: a released buffer holds no valid byte
  a_r7_clear_mask: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (mask_q == '0));
endmodule

// File: rtl/wcb_walker.sv
module wcb_walker
  import wcb_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [LINE_BYTES-1:0] mask,
  input  logic                  rdy,
  output logic                  busy,
  output logic                  wr_valid,
  output wsize_e                wr_size,
  output logic [OFF_W-1:0]      wr_off,
  output logic [WORD_BYTES-1:0] wr_be,
  output logic                  release_o
);
  logic                  run_q;
  logic [CIDX_W-1:0]     cur_q;
  pick_t                 pk;
  logic [CIDX_W:0]       nxt;
  logic                  advance;
  logic [LINE_BYTES-1:0] sh;

  always_comb begin
    pk      = pick_write(mask, cur_q);
    sh      = mask >> (int'(cur_q) * WORD_BYTES);
    nxt     = {1'b0, cur_q} + span_chunks(pk.sz);
    advance = run_q && (!pk.vld || rdy);
  end

  assign busy      = run_q;
  assign wr_valid  = run_q && pk.vld;
  assign wr_size   = pk.sz;
  assign wr_off    = OFF_W'(int'(cur_q) * WORD_BYTES);
  assign wr_be     = (pk.sz == SZ_DW) ? sh[WORD_BYTES-1:0] : '1;
  assign release_o = advance && nxt[CIDX_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cur_q <= '0;
    end else if (start) begin
      run_q <= 1'b1;
      cur_q <= '0;
    end else if (advance) begin
      cur_q <= nxt[CIDX_W-1:0];
      if (nxt[CIDX_W]) run_q <= 1'b0;
    end
  end

  // R4: a whole-line write starts at offset zero
  a_r4_line_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_size == SZ_LINE) |-> (wr_off == '0));
  // R5: wide writes are naturally aligned
  a_r5_align32: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_size == SZ_32) |-> (wr_off[4:0] == 5'd0));
  a_r5_align16: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_size == SZ_16) |-> (wr_off[3:0] == 4'd0));
  // R5: no empty word write is issued
  a_r5_be_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_size == SZ_DW) |-> (wr_be != '0));
endmodule

// File: rtl/wcb_coalesce.sv
module wcb_coalesce
  import wcb_pkg::*;
#(
  parameter int unsigned TAG_W = 26
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    st_valid,
  output logic                    st_ready,
  input  logic [TAG_W-1:0]        st_line,
  input  logic [CIDX_W-1:0]       st_word,
  input  logic [WORD_BYTES*8-1:0] st_data,
  input  logic [WORD_BYTES-1:0]   st_be,
  input  logic                    drain_req,
  output logic                    drain_done,
  output logic                    bw_valid,
  input  logic                    bw_ready,
  output logic [TAG_W-1:0]        bw_line,
  output logic [OFF_W-1:0]        bw_off,
  output logic [1:0]              bw_size,
  output logic [WORD_BYTES-1:0]   bw_be,
  output logic [LINE_BYTES*8-1:0] bw_data
);
  logic [NBUF-1:0]         busy_q;
  logic [BIDX_W-1:0]       old_q;
  logic [BIDX_W-1:0]       ev_idx_q;
  logic [TAG_W-1:0]        tag_a  [NBUF];
  logic [LINE_BYTES*8-1:0] data_a [NBUF];
  logic [LINE_BYTES-1:0]   mask_a [NBUF];

  logic [NBUF-1:0]   hit_vec;
  logic              hit_any, free_any;
  logic [BIDX_W-1:0] hit_idx, free_idx, tgt_idx, other_idx;
  logic              accept, alloc, start, walk_busy, rel;
  wsize_e            walk_sz;

  // Lookup: which buffer can take the store
  always_comb begin
    hit_any  = 1'b0;
    free_any = 1'b0;
    hit_idx  = '0;
    free_idx = '0;
    for (int i = NBUF - 1; i >= 0; i--) begin
      hit_vec[i] = busy_q[i] && (tag_a[i] == st_line) &&
                   !(walk_busy && ev_idx_q == BIDX_W'(i));
      if (hit_vec[i]) begin
        hit_any = 1'b1;
        hit_idx = BIDX_W'(i);
      end
      if (!busy_q[i]) begin
        free_any = 1'b1;
        free_idx = BIDX_W'(i);
      end
    end
  end

  assign st_ready   = !drain_req && (hit_any || free_any);
  assign accept     = st_valid && st_ready;
  assign alloc      = accept && !hit_any;
  assign tgt_idx    = hit_any ? hit_idx : free_idx;
  assign other_idx  = ~free_idx;
  assign start      = !walk_busy && busy_q[old_q] &&
                      (drain_req || (st_valid && !hit_any && !free_any));
  assign drain_done = ~|busy_q;

  // Line storage, one per buffer
  for (genvar g = 0; g < NBUF; g++) begin : g_buf
    wcb_line #(.TAG_W(TAG_W)) line_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .alloc   (alloc && tgt_idx == BIDX_W'(g)),
      .tag_in  (st_line),
      .wr_en   (accept && tgt_idx == BIDX_W'(g)),
      .wr_word (st_word),
      .wr_data (st_data),
      .wr_be   (st_be),
      .clr     (rel && ev_idx_q == BIDX_W'(g)),
      .tag_o   (tag_a[g]),
      .data_o  (data_a[g]),
      .mask_o  (mask_a[g])
    );
  end

  wcb_walker walk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .mask      (mask_a[ev_idx_q]),
    .rdy       (bw_ready),
    .busy      (walk_busy),
    .wr_valid  (bw_valid),
    .wr_size   (walk_sz),
    .wr_off    (bw_off),
    .wr_be     (bw_be),
    .release_o (rel)
  );

  assign bw_size = walk_sz;
  assign bw_line = tag_a[ev_idx_q];
  assign bw_data = data_a[ev_idx_q];

  // Occupancy and age tracking
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= '0;
      old_q    <= '0;
      ev_idx_q <= '0;
    end else begin
      if (start) ev_idx_q <= old_q;
      for (int i = 0; i < NBUF; i++) begin
        if (rel && ev_idx_q == BIDX_W'(i))        busy_q[i] <= 1'b0;
        else if (alloc && free_idx == BIDX_W'(i)) busy_q[i] <= 1'b1;
      end
      if (alloc)
        old_q <= (busy_q[other_idx] && !(rel && ev_idx_q == other_idx))
                 ? other_idx : free_idx;
      else if (rel)
        old_q <= ~ev_idx_q;
    end
  end

  // R3: a line is matched by at most one buffer
  a_r3_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(hit_vec) <= 1);
  // R6: no store is taken while draining
  a_r6_no_store_in_drain: assert property (@(posedge clk) disable iff (!rst_n)
    drain_req |-> !st_ready);
  // R7: a stalled bus write holds its fields
  a_r7_hold_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bw_valid && !bw_ready) |=> (bw_valid && $stable(bw_off) &&
                                 $stable(bw_size) && $stable(bw_line)));
  // R1: empty block issues nothing
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    drain_done |-> !bw_valid);
endmodule

// File: tb/wcb_coalesce_tb_top.sv
`timescale 1ns/1ps
module wcb_coalesce_tb_top;
  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          st_valid = 1'b0;
  logic          st_ready;
  logic [25:0]   st_line = '0;
  logic [3:0]    st_word = '0;
  logic [63:0]   st_data = '0;
  logic [7:0]    st_be = '0;
  logic          drain_req = 1'b0;
  logic          drain_done;
  logic          bw_valid;
  logic          bw_ready = 1'b1;
  logic [25:0]   bw_line;
  logic [6:0]    bw_off;
  logic [1:0]    bw_size;
  logic [7:0]    bw_be;
  logic [1023:0] bw_data;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  wcb_coalesce dut_i (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
    .st_line(st_line), .st_word(st_word), .st_data(st_data), .st_be(st_be),
    .drain_req(drain_req), .drain_done(drain_done), .bw_valid(bw_valid),
    .bw_ready(bw_ready), .bw_line(bw_line), .bw_off(bw_off),
    .bw_size(bw_size), .bw_be(bw_be), .bw_data(bw_data)
  );

  // Record of accepted bus writes
  int            n_wr = 0;
  logic [25:0]   c_line [32];
  logic [6:0]    c_off  [32];
  logic [1:0]    c_sz   [32];
  logic [7:0]    c_be   [32];
  logic [1023:0] c_dat  [32];

  always @(negedge clk) begin
    if (rst_n && bw_valid && bw_ready && n_wr < 32) begin
      c_line[n_wr] = bw_line;
      c_off[n_wr]  = bw_off;
      c_sz[n_wr]   = bw_size;
      c_be[n_wr]   = bw_be;
      c_dat[n_wr]  = bw_data;
      n_wr++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] wdat(input logic [7:0] seed, input int w);
    logic [63:0] d;
    for (int k = 0; k < 8; k++) d[8*k +: 8] = 8'(seed + 8'(w * 8 + k));
    return d;
  endfunction

  task automatic set_bw_ready(input logic v);
    @(posedge clk);
    #1 bw_ready = v;
  endtask

  task automatic do_store(input logic [25:0] ln, input int w,
                          input logic [7:0] seed, input logic [7:0] be);
    @(negedge clk);
    st_valid = 1'b1; st_line = ln; st_word = 4'(w);
    st_data = wdat(seed, w); st_be = be;
    #1;
    while (!st_ready) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    st_valid = 1'b0;
  endtask

  task automatic do_drain();
    @(negedge clk);
    drain_req = 1'b1;
    #1;
    while (!drain_done) begin
      @(negedge clk);
      #1;
    end
    drain_req = 1'b0;
  endtask

  task automatic chk_wr(input int i, input logic [25:0] ln, input int off,
                        input int sz, input logic [7:0] be, input string req);
    chk(i < n_wr, req, "write present", n_wr, i + 1);
    if (i < n_wr) begin
      chk(c_line[i] == ln, req, "line", c_line[i], ln);
      chk(c_off[i] == 7'(off), req, "offset", c_off[i], off);
      chk(c_sz[i] == 2'(sz), req, "size", c_sz[i], sz);
      chk(c_be[i] == be, req, "enables", c_be[i], be);
    end
  endtask

  task automatic t_reset();
    @(negedge clk); #1;
    chk(st_ready == 1'b1, "R1", "st_ready after reset", st_ready, 1);
    chk(bw_valid == 1'b0, "R1", "bw_valid after reset", bw_valid, 0);
    chk(drain_done == 1'b1, "R1", "drain_done after reset", drain_done, 1);
  endtask

  task automatic t_full_line();
    int base;
    base = n_wr;
    for (int w = 0; w < 16; w++) do_store(26'h100, w, 8'h33, 8'hFF);
    chk(drain_done == 1'b0, "R1", "occupied not done", drain_done, 0);
    do_drain();
    chk(n_wr - base == 1, "R4", "one write for full line", n_wr - base, 1);
    chk_wr(base, 26'h100, 0, 3, 8'hFF, "R4");
    chk(c_dat[base][127*8 +: 8] == 8'(8'h33 + 8'd127), "R4", "last byte",
        c_dat[base][127*8 +: 8], 8'(8'h33 + 8'd127));
  endtask

  task automatic t_holes();
    int base;
    int wl [12] = '{0, 1, 2, 3, 4, 5, 6, 10, 11, 13, 14, 15};
    base = n_wr;
    foreach (wl[j]) do_store(26'h155, wl[j], 8'h10, 8'hFF);
    do_store(26'h155, 8, 8'h40, 8'h0F);
    do_store(26'h155, 8, 8'hA0, 8'h3C);
    do_drain();
    chk(n_wr - base == 7, "R5", "write count with holes", n_wr - base, 7);
    chk_wr(base + 0, 26'h155, 0,   2, 8'hFF, "R5");
    chk_wr(base + 1, 26'h155, 32,  1, 8'hFF, "R5");
    chk_wr(base + 2, 26'h155, 48,  0, 8'hFF, "R5");
    chk_wr(base + 3, 26'h155, 64,  0, 8'h3F, "R5");
    chk_wr(base + 4, 26'h155, 80,  1, 8'hFF, "R5");
    chk_wr(base + 5, 26'h155, 104, 0, 8'hFF, "R5");
    chk_wr(base + 6, 26'h155, 112, 1, 8'hFF, "R5");
    if (n_wr - base >= 4) begin
      chk(c_dat[base+3][65*8 +: 8] == 8'(8'h40 + 8'd65), "R2", "kept byte 65",
          c_dat[base+3][65*8 +: 8], 8'(8'h40 + 8'd65));
      chk(c_dat[base+3][66*8 +: 8] == 8'(8'hA0 + 8'd66), "R2", "overwritten byte 66",
          c_dat[base+3][66*8 +: 8], 8'(8'hA0 + 8'd66));
      chk(c_dat[base+3][69*8 +: 8] == 8'(8'hA0 + 8'd69), "R2", "new byte 69",
          c_dat[base+3][69*8 +: 8], 8'(8'hA0 + 8'd69));
    end
  endtask

  task automatic t_pressure();
    int base;
    logic [6:0] off0;
    base = n_wr;
    set_bw_ready(1'b0);
    do_store(26'h200, 0, 8'h01, 8'hFF);
    do_store(26'h201, 0, 8'h02, 8'hFF);
    @(negedge clk);
    st_valid = 1'b1; st_line = 26'h202; st_word = 4'd0;
    st_data = wdat(8'h03, 0); st_be = 8'hFF;
    #1;
    chk(st_ready == 1'b0, "R3", "third line stalls", st_ready, 0);
    repeat (3) @(negedge clk);
    #1;
    chk(bw_valid == 1'b1, "R3", "older buffer flushing", bw_valid, 1);
    chk(bw_line == 26'h200, "R3", "older line chosen", bw_line, 26'h200);
    off0 = bw_off;
    repeat (2) @(negedge clk);
    #1;
    chk(bw_valid == 1'b1 && bw_off == off0, "R7", "held write stable", bw_off, off0);
    chk(st_ready == 1'b0, "R7", "no release before accept", st_ready, 0);
    set_bw_ready(1'b1);
    @(negedge clk); #1;
    while (!st_ready) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    st_valid = 1'b0;
    do_drain();
    chk(n_wr - base == 3, "R6", "three writes", n_wr - base, 3);
    chk_wr(base + 0, 26'h200, 0, 0, 8'hFF, "R3");
    chk_wr(base + 1, 26'h201, 0, 0, 8'hFF, "R6");
    chk_wr(base + 2, 26'h202, 0, 0, 8'hFF, "R6");
  endtask

  task automatic t_reuse();
    int base;
    base = n_wr;
    do_store(26'h300, 3, 8'h55, 8'h01);
    do_drain();
    chk(n_wr - base == 1, "R7", "reused buffer single write", n_wr - base, 1);
    chk_wr(base, 26'h300, 24, 0, 8'h01, "R7");
  endtask

  task automatic t_drain_block();
    @(negedge clk);
    drain_req = 1'b1;
    st_valid = 1'b1; st_line = 26'h3AA; st_word = 4'd1;
    st_data = wdat(8'h77, 1); st_be = 8'hFF;
    #1;
    chk(st_ready == 1'b0, "R6", "store held during drain", st_ready, 0);
    chk(drain_done == 1'b1, "R6", "empty reports done", drain_done, 1);
    @(negedge clk);
    drain_req = 1'b0;
    #1;
    chk(st_ready == 1'b1, "R6", "store taken after drain", st_ready, 1);
    @(negedge clk);
    st_valid = 1'b0;
    #1;
    chk(drain_done == 1'b0, "R1", "occupied after store", drain_done, 0);
    do_drain();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_full_line();
    t_holes();
    t_pressure();
    t_reuse();
    t_drain_block();
    repeat (4) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    total++;
    bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule